// File: doc/BRIEF.md
# Parallel Port Interface with Programmable Group Directions

This block gives a processor three 8-bit parallel ports, A, B and C, reached over an 8-bit register bus. It has an active-low select, active-low read and write strobes and a two-bit register address. Port C is split into two 4-bit halves. That gives four pin groups: A, B, C-high and C-low. Each group is set to input or output by one write-only control word. Only plain static input/output is supported, with no handshake signalling. Each pin group has three vectors: pin inputs, output values and output enables. A pad ring outside the block combines them.

The bus is sampled on the block clock. A write takes effect at the first clock edge on which both the select and the write strobe are seen low. It lands once for each strobe assertion. Read data is driven from a mux while a valid read is in progress. An input group returns its pins as registered at the previous edge. An output group returns its output latch.

Top module: `pio_port_unit`

## Requirements
- R1: After reset is asserted (active high), every output-enable bit is 0, every output latch is 0 and all four groups are inputs.
- R2: Register address 0 selects port A, 1 selects port B, 2 selects port C (both halves together) and 3 selects the control word.
- R3: A control write is accepted only when bit 7 is 1 and bits 6, 5 and 2 are 0. For an accepted word, bit 4 sets port A, bit 3 sets C-high, bit 1 sets port B and bit 0 sets C-low, where 1 means input and 0 means output.
- R4: A control write that is not accepted under R3 changes no direction and no latch.
- R5: An accepted control write clears all three output latches to 0 at the same edge that applies the new directions.
- R6: A write with select low stores the bus byte into the addressed port latch at the first clock edge of the strobe assertion. The value shows on the port output vector after that edge. Holding the strobe low does not store again.
- R7: A group set as output has all of its output-enable bits at 1. A group set as input has all of them at 0, and a write to it does not enable its pins.
- R8: Reading a port returns, for each group, the pins registered at the previous edge when the group is an input, or its output latch when it is an output. Port C is assembled half by half.
- R9: Reading address 3 returns 0.
- R10: The bus output enable is 1 only while select is low, read is low and write is high. The read data is 0 whenever the enable is 0.
- R11: A write strobe while select is high changes no latch and no direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| dout_oe | output | 1 | Read data enable |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A pin drive enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B pin drive enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C pin drive enables |

## Verification
An accepted control word changes the group directions and clears every output latch at the same clock edge. A wrong order between the two would show for one cycle as stale latch data with the enables already on. The bench writes non-zero data into every latch and then issues random valid and invalid control words. At the edge after each one it compares every output vector and enable vector with the model. This catches a cleared latch that lags the direction change and an invalid word that leaks through. Held write strobes with data that changes during the hold are also compared, to catch a second store within one assertion.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int DW     = 8;
    localparam int AW     = 2;
    localparam int NIB    = DW / 2;
    localparam int NREG   = 1 << AW;

    localparam logic [AW-1:0] ADR_A    = 2'd0;
    localparam logic [AW-1:0] ADR_B    = 2'd1;
    localparam logic [AW-1:0] ADR_C    = 2'd2;
    localparam logic [AW-1:0] ADR_CTRL = 2'd3;

    // bit positions inside the control word
    localparam int CW_SET = 7;
    localparam int CW_A   = 4;
    localparam int CW_CH  = 3;
    localparam int CW_B   = 1;
    localparam int CW_CL  = 0;

    // drive bits: 1 = group is an output
    typedef struct packed {
        logic a_drv;
        logic b_drv;
        logic ch_drv;
        logic cl_drv;
    } pio_drv_t;

    function automatic logic cw_accept(input logic [DW-1:0] w);
        return w[CW_SET] & ~w[6] & ~w[5] & ~w[2];
    endfunction

endpackage

// File: rtl/pio_bus_if.sv
module pio_bus_if
    import pio_pkg::*;
#(
    parameter int A_W = AW,
    localparam int N_SEL = 1 << A_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [A_W-1:0]   addr,
    output logic [N_SEL-1:0] sel,
    output logic             wr_pulse,
    output logic             rd_valid
);

    typedef struct packed {
        logic wr_act;
    } bus_s;

    bus_s st_d, st_q;
    logic wr_now;

    assign wr_now   = ~cs_n & ~wr_n;
    assign rd_valid = ~cs_n & ~rd_n & wr_n;
    assign wr_pulse = wr_now & ~st_q.wr_act;

    for (genvar i = 0; i < N_SEL; i++) begin : g_dec
        assign sel[i] = (addr == A_W'(i));
    end

    always_comb begin
        st_d        = st_q;
        st_d.wr_act = wr_now;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg
    import pio_pkg::*;
#(
    parameter int D_W = DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_pulse,
    input  logic           sel_ctrl,
    input  logic [D_W-1:0] wdata,
    output pio_drv_t       drv,
    output logic           clr
);

    typedef struct packed {
        pio_drv_t drv;
    } ctrl_s;

    ctrl_s st_d, st_q;
    logic  take;

    assign take = wr_pulse & sel_ctrl & cw_accept(wdata[DW-1:0]);
    assign clr  = take;
    assign drv  = st_q.drv;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.drv.a_drv  = ~wdata[CW_A];
            st_d.drv.b_drv  = ~wdata[CW_B];
            st_d.drv.ch_drv = ~wdata[CW_CH];
            st_d.drv.cl_drv = ~wdata[CW_CL];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/pio_group.sv
module pio_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic         clr,
    input  logic         drv,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pins_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rdata
);

    typedef struct packed {
        logic [W-1:0] lat;
        logic [W-1:0] smp;
    } grp_s;

    grp_s st_d, st_q;

    assign pin_out = st_q.lat;
    assign pin_oe  = {W{drv}};
    assign rdata   = drv ? st_q.lat : st_q.smp;

    always_comb begin
        st_d     = st_q;
        st_d.smp = pins_in;
        if (clr)     st_d.lat = '0;
        else if (ld) st_d.lat = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/pio_port_unit.sv
module pio_port_unit
    import pio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);

    logic [NREG-1:0] sel;
    logic            wr_pulse;
    logic            rd_valid;
    pio_drv_t        drv;
    logic            clr;
    logic [DW-1:0]   ra, rb, rc;
    logic [1:0]      c_drv;
    logic [DW-1:0]   rmux;

    pio_bus_if #(.A_W(AW)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .sel      (sel),
        .wr_pulse (wr_pulse),
        .rd_valid (rd_valid)
    );

    pio_ctrl_reg #(.D_W(DW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_pulse (wr_pulse),
        .sel_ctrl (sel[ADR_CTRL]),
        .wdata    (din),
        .drv      (drv),
        .clr      (clr)
    );

    pio_group #(.W(DW)) u_grp_a (
        .clk     (clk),
        .rst     (rst),
        .ld      (wr_pulse & sel[ADR_A]),
        .clr     (clr),
        .drv     (drv.a_drv),
        .wdata   (din),
        .pins_in (pa_in),
        .pin_out (pa_out),
        .pin_oe  (pa_oe),
        .rdata   (ra)
    );

    pio_group #(.W(DW)) u_grp_b (
        .clk     (clk),
        .rst     (rst),
        .ld      (wr_pulse & sel[ADR_B]),
        .clr     (clr),
        .drv     (drv.b_drv),
        .wdata   (din),
        .pins_in (pb_in),
        .pin_out (pb_out),
        .pin_oe  (pb_oe),
        .rdata   (rb)
    );

    assign c_drv = {drv.ch_drv, drv.cl_drv};

    for (genvar h = 0; h < 2; h++) begin : g_pc
        pio_group #(.W(NIB)) u_half (
            .clk     (clk),
            .rst     (rst),
            .ld      (wr_pulse & sel[ADR_C]),
            .clr     (clr),
            .drv     (c_drv[h]),
            .wdata   (din[h*NIB +: NIB]),
            .pins_in (pc_in[h*NIB +: NIB]),
            .pin_out (pc_out[h*NIB +: NIB]),
            .pin_oe  (pc_oe[h*NIB +: NIB]),
            .rdata   (rc[h*NIB +: NIB])
        );
    end

    always_comb begin
        unique case (addr)
            ADR_A:   rmux = ra;
            ADR_B:   rmux = rb;
            ADR_C:   rmux = rc;
            default: rmux = '0;
        endcase
    end

    assign dout_oe = rd_valid;
    assign dout    = rd_valid ? rmux : '0;

endmodule

// File: rtl/pio_port_unit_chk.sv
module pio_port_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] addr,
    input logic [7:0] din,
    input logic [7:0] dout,
    input logic       dout_oe,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_out,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_out,
    input logic [7:0] pc_oe
);

    logic wr_prev;
    logic wr_start;

    always_ff @(posedge clk) begin
        if (rst) wr_prev <= 1'b0;
        else     wr_prev <= ~cs_n & ~wr_n;
    end

    assign wr_start = ~cs_n & ~wr_n & ~wr_prev;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00 &&
                 pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    // R10
    bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n || !wr_n) |-> (!dout_oe && dout == 8'h00));

    // R7
    group_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        (pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF) &&
        (pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF) &&
        (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF));

    // R5
    ctrl_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_start && addr == 2'd3 && din[7] && din[6:5] == 2'b00 && !din[2])
        |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_start |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                       $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

    // R8
    read_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rd_n && wr_n && addr == 2'd0 && pa_oe == 8'hFF) |-> dout == pa_out);

    // R9
    ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rd_n && wr_n && addr == 2'd3) |-> dout == 8'h00);

endmodule

bind pio_port_unit pio_port_unit_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr    (addr),
    .din     (din),
    .dout    (dout),
    .dout_oe (dout_oe),
    .pa_out  (pa_out),
    .pa_oe   (pa_oe),
    .pb_out  (pb_out),
    .pb_oe   (pb_oe),
    .pc_out  (pc_out),
    .pc_oe   (pc_oe)
);

// File: tb/pio_port_unit_test.sv
module pio_port_unit_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model
    logic       m_a, m_b, m_ch, m_cl; // 1 = output
    logic [7:0] m_la, m_lb, m_lc;

    pio_port_unit uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic word_ok(input logic [7:0] w);
        return w[7] && w[6:5] == 2'b00 && !w[2];
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return m_a ? m_la : pa_in;
            2'd1: return m_b ? m_lb : pb_in;
            2'd2: return {m_ch ? m_lc[7:4] : pc_in[7:4], m_cl ? m_lc[3:0] : pc_in[3:0]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_pins(input string req);
        check8({req, " pa_out"}, pa_out, m_la);
        check8({req, " pb_out"}, pb_out, m_lb);
        check8({req, " pc_out"}, pc_out, m_lc);
        check8({req, " pa_oe"}, pa_oe, {8{m_a}});
        check8({req, " pb_oe"}, pb_oe, {8{m_b}});
        check8({req, " pc_oe"}, pc_oe, {{4{m_ch}}, {4{m_cl}}});
    endtask

    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        if (a == 2'd3) begin
            if (word_ok(d)) begin
                m_a = ~d[4]; m_ch = ~d[3]; m_b = ~d[1]; m_cl = ~d[0];
                m_la = 8'h00; m_lb = 8'h00; m_lc = 8'h00;
            end
        end else if (a == 2'd0) m_la = d;
        else if (a == 2'd1) m_lb = d;
        else m_lc = d;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        model_write(a, d);
        check_pins(req);
    endtask

    task automatic bus_read(input logic [1:0] a, input string req);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1;
        check8(req, dout, exp_read(a));
        check8({req, " R10 oe"}, {7'd0, dout_oe}, 8'h01);
        #1;
        cs_n = 1'b1; rd_n = 1'b1;
        #1;
        check8("R10 idle dout", dout, 8'h00);
        check8("R10 idle oe", {7'd0, dout_oe}, 8'h00);
    endtask

    task automatic set_pins(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        @(negedge clk);
        pa_in = a; pb_in = b; pc_in = c;
        @(negedge clk);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_a = 0; m_b = 0; m_ch = 0; m_cl = 0;
        m_la = 0; m_lb = 0; m_lc = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_pins("R1 reset");

        // R2 R3 R8: all outputs, distinct data per port
        bus_write(2'd3, 8'h80, "R3 all out");
        bus_write(2'd0, 8'h5A, "R2 write A");
        bus_write(2'd1, 8'hC3, "R2 write B");
        bus_write(2'd2, 8'h96, "R6 write C");
        bus_read(2'd0, "R8 read A latch");
        bus_read(2'd1, "R8 read B latch");
        bus_read(2'd2, "R8 read C latch");
        // R9
        bus_read(2'd3, "R9 ctrl read");

        // R4 invalid words ignored
        bus_write(2'd3, 8'hA0, "R4 bit5 set");
        bus_write(2'd3, 8'h04, "R4 bit7 clear");
        bus_write(2'd3, 8'h84, "R4 bit2 set");

        // R11 write with select high
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; din = 8'hFF;
        @(negedge clk);
        wr_n = 1'b1;
        check_pins("R11 deselected write");

        // R6 held strobe stores once
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = 2'd1; din = 8'h11;
        @(negedge clk);
        din = 8'h22;
        @(negedge clk);
        din = 8'h33;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        model_write(2'd1, 8'h11);
        check_pins("R6 held strobe");

        // R5 clear with new directions, mixed C: high input, low output
        bus_write(2'd3, 8'h88, "R5 clear mixed");
        // R7 write to input group does not enable pins
        bus_write(2'd2, 8'hE7, "R7 write C mixed");
        set_pins(8'h3C, 8'hA5, 8'h6B);
        bus_read(2'd2, "R8 read C mixed");
        bus_write(2'd3, 8'h9B, "R7 all in");
        bus_write(2'd0, 8'h77, "R7 write input A");
        set_pins(8'hF0, 8'h0F, 8'h81);
        bus_read(2'd0, "R8 read A pins");
        bus_read(2'd1, "R8 read B pins");
        bus_read(2'd2, "R8 read C pins");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom % 5);
            case (op)
                0: bus_write(2'($urandom % 3), 8'($urandom), "R6 random write");
                1: begin
                    logic [7:0] w;
                    w = 8'($urandom);
                    if ($urandom % 2 == 0) w = {1'b1, 2'b00, w[4:3], 1'b0, w[1:0]};
                    if (word_ok(w)) bus_write(2'd3, w, "R5 random ctrl");
                    else bus_write(2'd3, w, "R4 random ctrl");
                end
                2: set_pins(8'($urandom), 8'($urandom), 8'($urandom));
                default: bus_read(2'($urandom % 4), "R8 random read");
            endcase
        end

        // R1 reset mid-run
        bus_write(2'd3, 8'h80, "R3 pre reset");
        bus_write(2'd0, 8'hAA, "R6 pre reset");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_a = 0; m_b = 0; m_ch = 0; m_cl = 0;
        m_la = 0; m_lb = 0; m_lc = 0;
        check_pins("R1 reset again");

        done = 1'b1;
        report();
    end

endmodule